// File: doc/BRIEF.md
# Rolling Four-Activate Window Limiter

This block sits beside a DRAM command scheduler for one rank of an 8-bank DDR2 device. It watches the ACTIVATE strobe and limits how many row activations fall inside a rolling window whose length, in clock cycles, is set on an input. Any window of that length may hold at most four activates. The scheduler samples the activate-allowed output in a cycle before it issues an ACTIVATE in that cycle.

The block keeps the last four activates in a circular history. Each history entry holds a saturating age counter instead of an absolute timestamp, so the block never has to handle counter wraparound. An entry is young while its age is below the window length. Activates are blocked while all four entries are young. If an activate arrives while blocked, the block still records it and raises a one-cycle protocol error pulse. Other inter-command timings and bank state are handled elsewhere.

Top module: `faw_limiter`

## Requirements
- R1: After reset the history is empty, `act_ok_o` is 1 and `proto_err_o` is 0.
- R2: While fewer than four of the recorded activates are younger than the window, `act_ok_o` is 1. Any four activates can therefore be issued on consecutive cycles.
- R3: An activate sampled at the clock edge that ends cycle N has age k in cycle N+k. `act_ok_o` is 0 exactly while four recorded entries have age below `window_i`. With a window of 10 and activates in cycles N to N+3, `act_ok_o` is 0 in cycles N+4 to N+9 and 1 in cycle N+10.
- R4: An activate sampled while `act_ok_o` is 0 makes `proto_err_o` 1 for the following cycle only.
- R5: An activate sampled while `act_ok_o` is 1 leaves `proto_err_o` at 0 in the following cycle.
- R6: When `window_i` is 0, no entry counts as young and `act_ok_o` stays 1.
- R7: `act_ok_o` follows `window_i` combinationally. A change of window takes effect in the same cycle, with no clock edge needed.
- R8: Every sampled activate is recorded, including a blocked one. Each new activate replaces the oldest of the four entries, so only the last four activates govern `act_ok_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | ACTIVATE issued in this cycle |
| window_i | input | WIN_W | Rolling window length in cycles |
| act_ok_o | output | 1 | Another ACTIVATE is allowed this cycle |
| proto_err_o | output | 1 | Previous cycle issued an ACTIVATE while blocked |

## Verification
The main fault to look for is an age counter that is off by one, fails to saturate, or is written to the wrong history slot. Each of these makes `act_ok_o` change one cycle early or late at the edge of a window. Such a fault shows at the port in the first cycle where the fourth-youngest entry crosses the window length, which is at most `window_i` cycles after the fifth activate is attempted. A wrong replacement order shows up later, in the first blocked period after an activate has been recorded while blocked. Sweeping random window lengths and activate densities against an unbounded timestamp model therefore exposes these faults within a few windows.

// File: rtl/faw_pkg.sv
package faw_pkg;
  parameter int unsigned FAW_ACTS  = 4;
  parameter int unsigned FAW_WIN_W = 8;

  function automatic int unsigned faw_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/faw_hist_entry.sv
module faw_hist_entry #(
  parameter int unsigned WIN_W = faw_pkg::FAW_WIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             valid_o,
  output logic             young_o
);
  localparam logic [WIN_W-1:0] AGE_MAX = '1;

  logic [WIN_W-1:0] age_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q   <= AGE_MAX;
      valid_q <= 1'b0;
    end else if (wr_i) begin
      age_q   <= WIN_W'(1);
      valid_q <= 1'b1;
    end else if (valid_q && age_q != AGE_MAX) begin
      age_q   <= age_q + WIN_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign young_o = valid_q && (age_q < window_i);

  // R3: an entry that is not rewritten ages by one each cycle until it saturates
  a_r3_age_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !wr_i && age_q != AGE_MAX) |=> (age_q == $past(age_q) + WIN_W'(1)));

  // R8: a rewrite restarts the entry at age 1
  a_r8_write_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (valid_q && age_q == WIN_W'(1)));
endmodule

// File: rtl/faw_gate.sv
module faw_gate #(
  parameter int unsigned ACTS = faw_pkg::FAW_ACTS
) (
  input  logic [ACTS-1:0] young_i,
  output logic            act_ok_o
);
  localparam int unsigned CNT_W = $clog2(ACTS + 1);

  logic [CNT_W-1:0] young_cnt;

  always_comb begin
    young_cnt = '0;
    for (int i = 0; i < ACTS; i++) young_cnt = young_cnt + CNT_W'(young_i[i]);
  end

  assign act_ok_o = (young_cnt < CNT_W'(ACTS));
endmodule

// File: rtl/faw_err.sv
module faw_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic act_ok_i,
  output logic proto_err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= act_i && !act_ok_i;
  end

  assign proto_err_o = err_q;

  a_r4_err_on_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !act_ok_i) |=> proto_err_o);

  a_r5_no_err_when_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && act_ok_i) |=> !proto_err_o);
endmodule

// File: rtl/faw_limiter.sv
module faw_limiter #(
  parameter int unsigned ACTS  = faw_pkg::FAW_ACTS,
  parameter int unsigned WIN_W = faw_pkg::FAW_WIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             act_ok_o,
  output logic             proto_err_o
);
  localparam int unsigned PTR_W = faw_pkg::faw_idx_w(ACTS);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ACTS - 1);

  logic [PTR_W-1:0] wr_ptr_q;
  logic [ACTS-1:0]  wr_sel;
  logic [ACTS-1:0]  valid;
  logic [ACTS-1:0]  young;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wr_ptr_q <= '0;
    else if (act_i) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + PTR_W'(1);
  end

  for (genvar g = 0; g < ACTS; g++) begin : g_hist
    assign wr_sel[g] = act_i && (wr_ptr_q == PTR_W'(g));
    faw_hist_entry #(.WIN_W(WIN_W)) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_sel[g]),
      .window_i (window_i),
      .valid_o  (valid[g]),
      .young_o  (young[g])
    );
  end

  faw_gate #(.ACTS(ACTS)) u_gate (
    .young_i  (young),
    .act_ok_o (act_ok_o)
  );

  faw_err u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_i),
    .act_ok_i    (act_ok_o),
    .proto_err_o (proto_err_o)
  );

  // R2: with fewer than ACTS recorded entries the limiter cannot block
  a_r2_open_when_sparse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(valid) < ACTS) |-> act_ok_o);

  // R1: entries fill in order from empty
  a_r1_fill_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&valid)) |-> (valid == ((ACTS)'(1) << wr_ptr_q) - (ACTS)'(1)));

  // R6: zero window never blocks
  a_r6_zero_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_i == '0) |-> act_ok_o);
endmodule

// File: tb/sim_faw_limiter.sv
`timescale 1ns/1ps
module sim_faw_limiter;
  localparam int WIN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             act = 1'b0;
  logic [WIN_W-1:0] win = '0;
  logic             ok, err;

  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;
  longint hist_t[4];
  bit     hist_v[4];
  int     hptr = 0;
  bit     err_exp = 1'b0;

  always #5 clk = ~clk;

  faw_limiter #(.ACTS(4), .WIN_W(WIN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .window_i(win),
    .act_ok_o(ok), .proto_err_o(err)
  );

  function automatic bit model_ok();
    int n = 0;
    for (int i = 0; i < 4; i++)
      if (hist_v[i] && (cyc - hist_t[i]) < longint'(win)) n++;
    return n < 4;
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, got, exp);
    end
  endtask

  task automatic check_ok(input string tag);
    bit e = model_ok();
    check(ok, e, e ? tag : "R3");
  endtask

  // drive a at negedge, advance one cycle, check at next negedge
  task automatic step(input bit a, input string tag);
    bit okx = model_ok();
    act = a;
    @(posedge clk);
    err_exp = a && !okx;
    if (a) begin
      hist_t[hptr] = cyc; hist_v[hptr] = 1'b1; hptr = (hptr + 1) % 4;
    end
    cyc++;
    @(negedge clk);
    act = 1'b0;
    check_ok(tag);
    check(err, err_exp, err_exp ? "R4" : "R5");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) hist_v[i] = 1'b0;
    win = WIN_W'(10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc = 0;
    check(ok, 1'b1, "R1");
    check(err, 1'b0, "R1");

    // R2 / R3: four back-to-back then blocked through N+9, open at N+10
    for (int i = 0; i < 4; i++) step(1'b1, "R2");
    for (int i = 0; i < 6; i++) begin
      check(ok, 1'b0, "R3");
      step(1'b0, "R3");
    end
    check(ok, 1'b1, "R3");

    // R7: widen window combinationally, then narrow it
    win = WIN_W'(20); #1; check(ok, model_ok(), "R7"); check(ok, 1'b0, "R7");
    win = WIN_W'(10); #1; check(ok, 1'b1, "R7");

    // R8: blocked activate is recorded and replaces the oldest entry
    repeat (12) step(1'b0, "R2");
    step(1'b1, "R2");
    repeat (4) step(1'b0, "R2");
    repeat (3) step(1'b1, "R2");
    check(ok, 1'b0, "R8");
    step(1'b1, "R8");
    check(err, 1'b1, "R8");
    repeat (12) step(1'b0, "R8");

    // R6: zero window
    win = '0; #1;
    check(ok, 1'b1, "R6");
    repeat (10) step(1'b1, "R6");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) begin
        win = WIN_W'($urandom % 24); #1;
        check_ok("R7");
      end
      step(($urandom % 100) < 45, "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule